// File: doc/BRIEF.md
# Memory Dependence Scoreboard with Barriers

This block keeps a small table of the loads, stores and memory barriers that are in flight, one entry per operation, looked up by sequence number. When a load or store is inserted, the block picks the one older operation it must wait for, if any. An active barrier takes precedence over the external predictor's guess. A waiting operation is recorded as a dependent of that producer. When a store or barrier completes, its dependents are woken. Any operation whose memory ordering and source registers are both settled is handed to the issue logic through a one-per-cycle ready output.

Commands arrive one per cycle on a single command port. They cover a normal insert, an insert that skips the dependence check, a barrier insert, a register-ready notice, a release for operations that skipped the check, a completion, and a squash of everything younger than a given point in one thread. Two counters record how many loads and how many stores had to wait at insert time.

Top module: `mem_dep_board`

## Requirements
- R1: After reset the table is empty: `full` and `rdy_valid` are low and both conflict counters read zero.
- R2: Producer choice works as follows. A load (kind 0) takes the full-barrier sequence number while such a barrier is active. A store (kind 1) takes the store-blocking barrier sequence number while one is active. Any other insert takes `pred_seq`. During a normal insert (op 1), `ins_dep` is high exactly when the chosen producer is nonzero and is present in the table. A zero or absent producer means the operation does not wait.
- R3: A normal insert with no dependence is marked memory-ready at once. If `cmd_regs_rdy` is also high, its sequence number appears on `rdy_seq` two clock edges later.
- R4: A normal insert with a dependence does not reach the output. It increments `conflict_loads` (kind 0) or `conflict_stores` (kind 1) by exactly one.
- R5: Completion (op 6) of a store or barrier wakes its dependents. Each dependent with ready registers goes to the output. Every other dependent only becomes memory-ready and goes out on a later register-ready notice. Completion of a load wakes nothing.
- R6: A barrier insert (op 3) with kind 2 blocks both loads and stores. With kind 3 it blocks only stores. A later barrier replaces the recorded sequence number. Completion clears a blocking condition only if its recorded sequence number equals the completing barrier's.
- R7: A register-ready notice (op 4) marks the entry. It sends the entry to the output only if the entry is already memory-ready.
- R8: An insert that skips the dependence check (op 2) never reaches the output through a register-ready notice. A release command (op 5) sends it to the output.
- R9: A squash (op 7) with thread `cmd_tid` and point `cmd_seq` removes every entry of that thread whose sequence number is above the point. Removed entries never reach the output. A barrier condition whose sequence number belongs to a removed entry is cleared.
- R10: `full` is high when all table entries are in use. An insert while `full` is high is ignored.
- R11: While `rdy_valid` is high and `rdy_ready` is low, `rdy_seq` holds. One entry moves per accepted transfer. When several entries are ready together, the lowest table slot goes first; slots are taken lowest-free-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 none, 1 insert, 2 insert without check, 3 barrier insert, 4 registers ready, 5 release, 6 complete, 7 squash |
| cmd_seq | input | SEQ_W | Sequence number of the operation, or the squash point |
| cmd_tid | input | TID_W | Thread of the operation or squash |
| cmd_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 store-only barrier |
| cmd_regs_rdy | input | 1 | Source registers already ready at insert |
| pred_seq | input | SEQ_W | Predicted producer sequence number, 0 for none |
| full | output | 1 | All table entries in use |
| ins_dep | output | 1 | Current normal insert must wait on a producer |
| rdy_valid | output | 1 | Ready operation offered |
| rdy_ready | input | 1 | Issue logic accepts the offered operation |
| rdy_seq | output | SEQ_W | Sequence number of the offered operation |
| conflict_loads | output | CNT_W | Loads that had to wait |
| conflict_stores | output | CNT_W | Stores that had to wait |

## Verification
On every cycle the assertions check several things. The held output under back-pressure must stay fixed, and the counters may only step by one after a load or store that waited. No entry of a squashed thread above the squash point may survive, and a full table must stay full across an insert. Which operations finally come out depends on ordering, so only the bench scenarios can show it. These cover producers that are absent, barrier override and replacement, and wake against memory-ready marking. They also cover release of unchecked inserts, squash clearing a barrier, and the lowest-slot ordering.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_INS    = 3'd1,
        OP_INS_NS = 3'd2,
        OP_INS_BAR= 3'd3,
        OP_REGS   = 3'd4,
        OP_NS_RDY = 3'd5,
        OP_DONE   = 3'd6,
        OP_SQUASH = 3'd7
    } mdu_op_e;

    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_FULLBAR = 2'd2,
        K_WRBAR   = 2'd3
    } mdu_kind_e;

    typedef struct packed {
        logic      valid;
        logic      regs_rdy;
        logic      mem_rdy;
        logic      pend;
        mdu_kind_e kind;
    } mdu_flags_t;

    // Only stores and barriers release waiters when they complete.
    function automatic logic can_wake(mdu_kind_e k);
        return k != K_LOAD;
    endfunction

    function automatic logic is_insert(mdu_op_e o);
        return (o == OP_INS) || (o == OP_INS_NS) || (o == OP_INS_BAR);
    endfunction

endpackage

// File: rtl/mdu_first_set.sv
module mdu_first_set #(
    parameter int W = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mdu_seq_match.sv
module mdu_seq_match #(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_tbl,
    input  logic [SEQ_W-1:0]            key,
    output logic                        hit,
    output logic [DEPTH-1:0]            match
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = valid[i] && (key != '0) && (seq_tbl[i] == key);
    end
    assign hit = |match;
endmodule

// File: rtl/mem_dep_board.sv
module mem_dep_board
    import mdu_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int TID_W = 1,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [TID_W-1:0] cmd_tid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_regs_rdy,
    input  logic [SEQ_W-1:0] pred_seq,
    output logic             full,
    output logic             ins_dep,
    output logic             rdy_valid,
    input  logic             rdy_ready,
    output logic [SEQ_W-1:0] rdy_seq,
    output logic [CNT_W-1:0] conflict_loads,
    output logic [CNT_W-1:0] conflict_stores
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    mdu_flags_t [DEPTH-1:0]            flags_q, flags_d;
    logic       [DEPTH-1:0][DEPTH-1:0] deps_q, deps_d;
    logic       [DEPTH-1:0][SEQ_W-1:0] seq_tbl, seq_d;
    logic       [DEPTH-1:0][TID_W-1:0] tid_tbl, tid_d;
    logic       [DEPTH-1:0]            valid_vec, pend_vec;

    logic             lb_act_q, sb_act_q;
    logic [SEQ_W-1:0] lb_seq_q, sb_seq_q;
    logic             out_valid_q;
    logic [SEQ_W-1:0] out_seq_q;
    logic [CNT_W-1:0] cl_q, cs_q;

    mdu_op_e   op;
    mdu_kind_e kind;
    assign op   = cmd_valid ? mdu_op_e'(cmd_op) : OP_NONE;
    assign kind = mdu_kind_e'(cmd_kind);

    for (genvar i = 0; i < DEPTH; i++) begin : g_vec
        assign valid_vec[i] = flags_q[i].valid;
        assign pend_vec[i]  = flags_q[i].pend;
    end

    // Producer choice: an active barrier overrides the predictor.
    logic [SEQ_W-1:0] prod_seq;
    always_comb begin
        if (kind == K_LOAD && lb_act_q)       prod_seq = lb_seq_q;
        else if (kind == K_STORE && sb_act_q) prod_seq = sb_seq_q;
        else                                  prod_seq = pred_seq;
    end

    logic             prod_hit, cmd_hit;
    logic [DEPTH-1:0] prod_match, cmd_match;

    mdu_seq_match #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_prod_cam (
        .valid(valid_vec), .seq_tbl(seq_tbl), .key(prod_seq),
        .hit(prod_hit), .match(prod_match)
    );
    mdu_seq_match #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_cmd_cam (
        .valid(valid_vec), .seq_tbl(seq_tbl), .key(cmd_seq),
        .hit(cmd_hit), .match(cmd_match)
    );

    logic             free_found, pick_found;
    logic [IDX_W-1:0] free_idx, pick_idx;

    mdu_first_set #(.W(DEPTH)) u_alloc (
        .req(~valid_vec), .found(free_found), .idx(free_idx)
    );
    mdu_first_set #(.W(DEPTH)) u_pick (
        .req(pend_vec), .found(pick_found), .idx(pick_idx)
    );

    logic take_ins, take_dep, no_dep_now, load_out;
    assign full       = !free_found;
    assign take_ins   = is_insert(op) && free_found;
    assign take_dep   = take_ins && (op == OP_INS) && prod_hit;
    assign no_dep_now = (op == OP_INS) && !prod_hit;
    assign ins_dep    = take_dep;
    assign load_out   = pick_found && (!out_valid_q || rdy_ready);

    logic [DEPTH-1:0] done_vec, sq_vec, kill, wake;
    mdu_kind_e        done_kind;
    logic             sq_hits_lb, sq_hits_sb;

    always_comb begin
        done_vec   = (op == OP_DONE) ? cmd_match : '0;
        wake       = '0;
        done_kind  = K_LOAD;
        sq_hits_lb = 1'b0;
        sq_hits_sb = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            sq_vec[j] = (op == OP_SQUASH) && flags_q[j].valid &&
                        (tid_tbl[j] == cmd_tid) && (seq_tbl[j] > cmd_seq);
            if (done_vec[j]) begin
                done_kind = flags_q[j].kind;
                if (can_wake(flags_q[j].kind)) wake = wake | deps_q[j];
            end
            if (sq_vec[j] && seq_tbl[j] == lb_seq_q) sq_hits_lb = 1'b1;
            if (sq_vec[j] && seq_tbl[j] == sb_seq_q) sq_hits_sb = 1'b1;
        end
        kill = done_vec | sq_vec;
    end

    always_comb begin
        flags_d = flags_q;
        deps_d  = deps_q;
        seq_d   = seq_tbl;
        tid_d   = tid_tbl;
        for (int j = 0; j < DEPTH; j++) begin
            if (load_out && pick_idx == IDX_W'(j)) flags_d[j].pend = 1'b0;
            if (wake[j] && flags_q[j].valid) begin
                if (flags_q[j].regs_rdy) flags_d[j].pend    = 1'b1;
                else                     flags_d[j].mem_rdy = 1'b1;
            end
            if (op == OP_REGS && cmd_match[j]) begin
                flags_d[j].regs_rdy = 1'b1;
                if (flags_q[j].mem_rdy) flags_d[j].pend = 1'b1;
            end
            if (op == OP_NS_RDY && cmd_match[j]) flags_d[j].pend = 1'b1;
            deps_d[j] = deps_d[j] & ~kill;
            if (kill[j]) begin
                flags_d[j] = '0;
                deps_d[j]  = '0;
            end
            if (take_ins && free_idx == IDX_W'(j)) begin
                flags_d[j].valid    = 1'b1;
                flags_d[j].regs_rdy = cmd_regs_rdy;
                flags_d[j].mem_rdy  = no_dep_now;
                flags_d[j].pend     = no_dep_now && cmd_regs_rdy;
                flags_d[j].kind     = kind;
                seq_d[j]            = cmd_seq;
                tid_d[j]            = cmd_tid;
                deps_d[j]           = '0;
            end
            if (take_dep && prod_match[j]) deps_d[j][free_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q     <= '0;
            deps_q      <= '0;
            seq_tbl     <= '0;
            tid_tbl     <= '0;
            lb_act_q    <= 1'b0;
            sb_act_q    <= 1'b0;
            lb_seq_q    <= '0;
            sb_seq_q    <= '0;
            out_valid_q <= 1'b0;
            out_seq_q   <= '0;
            cl_q        <= '0;
            cs_q        <= '0;
        end else begin
            flags_q <= flags_d;
            deps_q  <= deps_d;
            seq_tbl <= seq_d;
            tid_tbl <= tid_d;

            if (load_out) begin
                out_valid_q <= 1'b1;
                out_seq_q   <= seq_tbl[pick_idx];
            end else if (rdy_ready) begin
                out_valid_q <= 1'b0;
            end

            if (take_dep) begin
                if (kind == K_LOAD) cl_q <= cl_q + 1'b1;
                else                cs_q <= cs_q + 1'b1;
            end

            if (take_ins && op == OP_INS_BAR) begin
                if (kind == K_FULLBAR) begin
                    lb_act_q <= 1'b1;
                    lb_seq_q <= cmd_seq;
                end
                if (kind == K_FULLBAR || kind == K_WRBAR) begin
                    sb_act_q <= 1'b1;
                    sb_seq_q <= cmd_seq;
                end
            end else if (op == OP_DONE && cmd_hit) begin
                if (done_kind == K_FULLBAR && lb_seq_q == cmd_seq) lb_act_q <= 1'b0;
                if ((done_kind == K_FULLBAR || done_kind == K_WRBAR) &&
                    sb_seq_q == cmd_seq) sb_act_q <= 1'b0;
            end else if (op == OP_SQUASH) begin
                if (sq_hits_lb) lb_act_q <= 1'b0;
                if (sq_hits_sb) sb_act_q <= 1'b0;
            end
        end
    end

    assign rdy_valid       = out_valid_q;
    assign rdy_seq         = out_seq_q;
    assign conflict_loads  = cl_q;
    assign conflict_stores = cs_q;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int TID_W = 1,
    parameter int CNT_W = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cmd_valid,
    input logic [2:0]                  cmd_op,
    input logic [SEQ_W-1:0]            cmd_seq,
    input logic [TID_W-1:0]            cmd_tid,
    input logic [1:0]                  cmd_kind,
    input logic                        full,
    input logic                        ins_dep,
    input logic                        rdy_valid,
    input logic                        rdy_ready,
    input logic [SEQ_W-1:0]            rdy_seq,
    input logic [CNT_W-1:0]            conflict_loads,
    input logic [CNT_W-1:0]            conflict_stores,
    input logic [DEPTH-1:0]            valid_vec,
    input logic [DEPTH-1:0][SEQ_W-1:0] seq_tbl,
    input logic [DEPTH-1:0][TID_W-1:0] tid_tbl
);
    logic             sq_seen;
    logic [SEQ_W-1:0] sq_point;
    logic [TID_W-1:0] sq_thread;
    logic             young_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_seen   <= 1'b0;
            sq_point  <= '0;
            sq_thread <= '0;
        end else begin
            sq_seen   <= cmd_valid && cmd_op == 3'd7;
            sq_point  <= cmd_seq;
            sq_thread <= cmd_tid;
        end
    end

    always_comb begin
        young_left = 1'b0;
        for (int j = 0; j < DEPTH; j++)
            if (valid_vec[j] && tid_tbl[j] == sq_thread && seq_tbl[j] > sq_point)
                young_left = 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !rdy_valid && !full && conflict_loads == '0 && conflict_stores == '0);

    assert_dep_only_on_insert_R2: assert property (@(posedge clk) disable iff (rst)
        ins_dep |-> cmd_valid && cmd_op == 3'd1 && !full);

    assert_load_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(conflict_loads) |->
            conflict_loads == $past(conflict_loads) + 1'b1 &&
            $past(ins_dep) && $past(cmd_kind) == 2'd0);

    assert_store_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(conflict_stores) |->
            conflict_stores == $past(conflict_stores) + 1'b1 &&
            $past(ins_dep) && $past(cmd_kind) == 2'd1);

    assert_squash_clean_R9: assert property (@(posedge clk) disable iff (rst)
        sq_seen |-> !young_left);

    assert_full_blocks_insert_R10: assert property (@(posedge clk) disable iff (rst)
        full && cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd3) |=> full);

    assert_hold_under_stall_R11: assert property (@(posedge clk) disable iff (rst)
        rdy_valid && !rdy_ready |=> rdy_valid && $stable(rdy_seq));
endmodule

bind mem_dep_board mdu_checker #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W), .CNT_W(CNT_W)
) u_mdu_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_seq(cmd_seq), .cmd_tid(cmd_tid), .cmd_kind(cmd_kind),
    .full(full), .ins_dep(ins_dep), .rdy_valid(rdy_valid),
    .rdy_ready(rdy_ready), .rdy_seq(rdy_seq),
    .conflict_loads(conflict_loads), .conflict_stores(conflict_stores),
    .valid_vec(valid_vec), .seq_tbl(seq_tbl), .tid_tbl(tid_tbl)
);

// File: tb/mem_dep_board_test.sv
module mem_dep_board_test;
    localparam int DEPTH = 16;
    localparam int SEQ_W = 16;
    localparam int TID_W = 1;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic [SEQ_W-1:0] cmd_seq = '0;
    logic [TID_W-1:0] cmd_tid = '0;
    logic [1:0]       cmd_kind = 2'd0;
    logic             cmd_regs_rdy = 1'b0;
    logic [SEQ_W-1:0] pred_seq = '0;
    logic             full, ins_dep, rdy_valid;
    logic             rdy_ready = 1'b1;
    logic [SEQ_W-1:0] rdy_seq;
    logic [CNT_W-1:0] conflict_loads, conflict_stores;

    always #4 clk = ~clk;

    mem_dep_board #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_seq(cmd_seq), .cmd_tid(cmd_tid), .cmd_kind(cmd_kind),
        .cmd_regs_rdy(cmd_regs_rdy), .pred_seq(pred_seq), .full(full),
        .ins_dep(ins_dep), .rdy_valid(rdy_valid), .rdy_ready(rdy_ready),
        .rdy_seq(rdy_seq), .conflict_loads(conflict_loads),
        .conflict_stores(conflict_stores)
    );

    int checks = 0;
    int errors = 0;
    int got_n  = 0;
    int got [0:255];
    logic last_dep;
    logic rnd_mode = 1'b0;

    // random-phase model: state 0 waits for registers, 1 owed to output, 2 delivered
    int lseq [0:15];
    int lst  [0:15];
    int ln = 0;

    task automatic check_eq(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int seen(int s);
        for (int i = 0; i < got_n; i++) if (got[i] == s) return 1;
        return 0;
    endfunction

    function automatic int find_live(int s);
        for (int i = 0; i < ln; i++) if (lseq[i] == s) return i;
        return -1;
    endfunction

    task automatic tick();
        if (rdy_valid && rdy_ready) begin
            if (got_n < 256) got[got_n] = int'(rdy_seq);
            got_n++;
            if (rnd_mode) begin
                int k;
                k = find_live(int'(rdy_seq));
                checks++;
                if (k < 0 || lst[k] != 1) begin
                    errors++;
                    $display("FAIL R3 random: actual seq %0d expected an owed entry", rdy_seq);
                end else lst[k] = 2;
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(int op, int seq, int tid, int kind, int regs, int pred);
        cmd_valid    = 1'b1;
        cmd_op       = 3'(op);
        cmd_seq      = SEQ_W'(seq);
        cmd_tid      = TID_W'(tid);
        cmd_kind     = 2'(kind);
        cmd_regs_rdy = regs[0];
        pred_seq     = SEQ_W'(pred);
        #1;
        last_dep = ins_dep;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic drain(int n);
        rdy_ready = 1'b1;
        repeat (n) tick();
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int nseq;
        seed = int'($urandom(32'd77));
        repeat (3) @(posedge clk);
        #1;
        check_eq(int'(rdy_valid), 0, "R1 rdy_valid after reset");
        check_eq(int'(full), 0, "R1 full after reset");
        check_eq(int'(conflict_loads) + int'(conflict_stores), 0, "R1 counters after reset");
        rst = 1'b0;
        tick();

        // R2/R3: no producer, registers ready
        got_n = 0;
        cmd(1, 10, 0, 0, 1, 0);
        check_eq(int'(last_dep), 0, "R2 zero producer");
        drain(4);
        check_eq(got_n, 1, "R3 count"); check_eq(seen(10), 1, "R3 seq 10 out");

        // R4/R5: dependents on a store
        cmd(1, 20, 0, 1, 1, 0);
        cmd(1, 21, 0, 0, 1, 20);
        check_eq(int'(last_dep), 1, "R2 predicted producer present");
        cmd(1, 22, 0, 0, 0, 20);
        drain(4);
        got_n = 0;
        drain(3);
        check_eq(got_n, 0, "R4 waiting loads held");
        cmd(6, 20, 0, 1, 0, 0);
        drain(4);
        check_eq(got_n, 1, "R5 wake count"); check_eq(seen(21), 1, "R5 ready dependent out");
        cmd(4, 22, 0, 0, 0, 0);
        drain(4);
        check_eq(seen(22), 1, "R5 memory-ready dependent out after regs");

        // R7 and R5 load completion wakes nothing
        got_n = 0;
        cmd(1, 30, 0, 0, 0, 21);
        cmd(4, 30, 0, 0, 0, 0);
        drain(3);
        check_eq(got_n, 0, "R7 regs ready but waiting");
        cmd(6, 21, 0, 0, 0, 0);
        drain(4);
        check_eq(got_n, 0, "R5 load completion no wake");

        // R2 absent producer
        cmd(1, 31, 0, 0, 1, 99);
        check_eq(int'(last_dep), 0, "R2 absent producer");
        drain(4);
        check_eq(seen(31), 1, "R2 absent producer goes out");

        // R6 full barrier
        got_n = 0;
        cmd(3, 40, 0, 2, 0, 0);
        cmd(1, 41, 0, 0, 1, 0);
        check_eq(int'(last_dep), 1, "R6 full barrier blocks load");
        cmd(1, 42, 0, 1, 1, 0);
        check_eq(int'(last_dep), 1, "R6 full barrier blocks store");
        drain(3);
        check_eq(got_n, 0, "R6 blocked ops held");
        cmd(6, 40, 0, 2, 0, 0);
        drain(5);
        check_eq(seen(41) + seen(42), 2, "R6 barrier completion wakes both");
        cmd(1, 43, 0, 0, 1, 0);
        check_eq(int'(last_dep), 0, "R6 load flag cleared");

        // R6 store-only barrier and replacement
        cmd(3, 50, 0, 3, 0, 0);
        cmd(1, 51, 0, 0, 1, 0);
        check_eq(int'(last_dep), 0, "R6 store barrier lets loads pass");
        cmd(1, 52, 0, 1, 1, 0);
        check_eq(int'(last_dep), 1, "R6 store barrier blocks store");
        cmd(3, 53, 0, 3, 0, 0);
        drain(4);
        got_n = 0;
        cmd(6, 50, 0, 3, 0, 0);
        drain(4);
        check_eq(seen(52), 1, "R6 older barrier wakes its store");
        cmd(1, 54, 0, 1, 1, 0);
        check_eq(int'(last_dep), 1, "R6 newer barrier still blocks");
        cmd(6, 53, 0, 3, 0, 0);
        drain(4);
        check_eq(seen(54), 1, "R6 newer barrier wakes");
        cmd(1, 55, 0, 1, 1, 0);
        check_eq(int'(last_dep), 0, "R6 store flag cleared on match");
        drain(4);

        // R8 unchecked insert
        got_n = 0;
        cmd(2, 60, 0, 1, 1, 0);
        cmd(4, 60, 0, 0, 0, 0);
        drain(4);
        check_eq(got_n, 0, "R8 no output before release");
        cmd(5, 60, 0, 0, 0, 0);
        drain(4);
        check_eq(seen(60), 1, "R8 release goes out");

        // R9 squash
        got_n = 0;
        cmd(1, 70, 1, 0, 0, 0);
        cmd(3, 71, 1, 2, 0, 0);
        cmd(1, 72, 1, 0, 0, 0);
        check_eq(int'(last_dep), 1, "R9 setup dependent on barrier");
        cmd(7, 70, 1, 0, 0, 0);
        cmd(4, 72, 1, 0, 0, 0);
        cmd(4, 70, 1, 0, 0, 0);
        cmd(1, 73, 0, 0, 1, 0);
        check_eq(int'(last_dep), 0, "R9 squash clears barrier");
        drain(5);
        check_eq(got_n, 2, "R9 count");
        check_eq(seen(70) + seen(73), 2, "R9 survivors out");
        check_eq(int'(conflict_loads), 5, "R4 load counter");
        check_eq(int'(conflict_stores), 3, "R4 store counter");

        // R10 capacity
        cmd(7, 0, 0, 0, 0, 0);
        cmd(7, 0, 1, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) cmd(1, 100 + i, 0, 0, 0, 0);
        check_eq(int'(full), 1, "R10 full at capacity");
        got_n = 0;
        cmd(1, 116, 0, 0, 1, 0);
        cmd(4, 116, 0, 0, 0, 0);
        drain(4);
        check_eq(got_n, 0, "R10 insert while full ignored");
        check_eq(int'(full), 1, "R10 still full");
        cmd(6, 100, 0, 0, 0, 0);
        check_eq(int'(full), 0, "R10 free after completion");

        // R11 hold and order
        rdy_ready = 1'b0;
        got_n = 0;
        cmd(4, 103, 0, 0, 0, 0);
        cmd(4, 102, 0, 0, 0, 0);
        cmd(4, 101, 0, 0, 0, 0);
        repeat (3) tick();
        check_eq(int'(rdy_valid), 1, "R11 offered while stalled");
        check_eq(int'(rdy_seq), 103, "R11 first offer held");
        repeat (3) tick();
        check_eq(int'(rdy_seq), 103, "R11 held across stall");
        drain(6);
        check_eq(got_n, 3, "R11 count");
        if (got_n == 3) begin
            check_eq(got[1], 101, "R11 lowest slot next");
            check_eq(got[2], 102, "R11 then next slot");
        end
        cmd(7, 0, 0, 0, 0, 0);
        drain(3);

        // random loads and completions
        rnd_mode = 1'b1;
        nseq = 200;
        for (int it = 0; it < 400; it++) begin
            int r, k;
            rdy_ready = ($urandom % 4) != 0;
            r = int'($urandom % 3);
            if (r == 0 && ln < 15) begin
                int rg;
                rg = int'($urandom % 2);
                lseq[ln] = nseq; lst[ln] = rg; ln++;
                cmd(1, nseq, 0, 0, rg, 0);
                nseq++;
            end else if (r == 1 && ln > 0) begin
                k = int'($urandom % ln);
                if (lst[k] == 0) begin
                    lst[k] = 1;
                    cmd(4, lseq[k], 0, 0, 0, 0);
                end else tick();
            end else if (ln > 0) begin
                k = int'($urandom % ln);
                if (lst[k] != 1) begin
                    int s;
                    s = lseq[k];
                    ln--; lseq[k] = lseq[ln]; lst[k] = lst[ln];
                    cmd(6, s, 0, 0, 0, 0);
                end else tick();
            end else tick();
        end
        drain(40);
        begin
            int owed;
            owed = 0;
            for (int i = 0; i < ln; i++) if (lst[i] == 1) owed++;
            check_eq(owed, 0, "R3 random all ready entries delivered");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule